// File: doc/BRIEF.md
# Per-Bit Input Delay Calibration Sweeper

This block trains the receive side of a wide source-synchronous parallel bus whose bits each pass through an adjustable input delay placed ahead of the deserializer. While it calibrates, the far end transmits a free-running binary ramp on every lane. After a start pulse the block moves the delay setting of all bits together through each tap value in ascending order. At each tap it lets the line settle and then watches a programmable number of samples. It flags every bit that breaks the rule "this sample equals the previous sample plus one".

Each tap yields one row of a pass/fail map with one flag per bit. Once the last tap has been tested, the block looks down each bit's column of the map and finds that bit's longest unbroken run of clean taps. It picks the centre of that run and loads all the chosen taps in one strobe. A bit with no clean run of useful width is reported in a failure mask and gets tap zero. Any row of the map can be read back at any time through a row selector. The sweep can also rerun with a different observation length.

Top module: `dly_cal_sweeper`

## Requirements
- R1: While reset is high and in the first cycle after it, busy, done, tap_load and fail_mask are all zero, and every tap field of tap_out reads zero.
- R2: The bus is four lanes of 14 bits, where lane l occupies lane_data bits [14l+13:14l]. A bit counts as in error in a cycle when it differs from the same bit of (previous lane sample + 1) modulo 2^14, so a wrap from 16383 to 0 is correct.
- R3: After each tap change, 16 settle cycles pass in which errors are ignored. Only samples in the observation window that follows are recorded.
- R4: The sweep applies taps 0, 1, ..., 31 in order. All bits carry the same tap, field b of tap_out being bits [5b+4:5b]. Each tap is applied with a one-cycle strobe on every bit of tap_load.
- R5: The observation window lasts max(dwell_cfg, 1024) cycles, latched at start. busy is therefore high for exactly 32*(17+D)+2 cycles per sweep.
- R6: Row t of the map, read combinationally on row_bits when row_sel = t, has bit b set exactly when bit b showed at least one error during the window at tap t.
- R7: A good bit receives start + (length-1)/2 (rounded down) of its longest run of consecutive clean taps. When two runs have the same length, the run at the lower taps wins.
- R8: A bit whose longest clean run is shorter than 3 taps has its fail_mask bit set and receives tap 0.
- R9: At the end of a sweep, done is high for exactly one cycle. In that same cycle tap_load is all ones, tap_out carries every final tap, and fail_mask holds the new result.
- R10: A start pulse while busy is ignored. The running sweep neither restarts nor changes length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock of the deserialized lanes |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a calibration sweep when idle |
| dwell_cfg | input | 16 | Requested observation samples per tap (floor 1024) |
| lane_data | input | 56 | Four 14-bit deserialized lane samples |
| tap_out | output | 280 | Delay tap per bit, 5 bits each |
| tap_load | output | 56 | Per-bit one-cycle load strobe for tap_out |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle completion pulse |
| fail_mask | output | 56 | Bits with no usable clean window |
| row_sel | input | 5 | Map row (tap) to read back |
| row_bits | output | 56 | Error flags of the selected tap row |

## Verification
The bench assigns each bit a fault profile over the 32 taps. The profiles cover a fully clean column, a fully dead column, ties between equal runs, a run of exactly three, a run of only two, and long runs at both ends of the range. A design that broke ties upward, centred by rounding up, or took a two-tap run as usable would load a wrong tap or clear a wrong fail flag. Faults are injected only at points where no carry crosses the faulty bit, and one lane wraps through 16383 to 0 during each sweep. A checker that used the wrong previous value, or that did not wrap modulo the lane width, would therefore flag clean bits. Every tap change is followed by eight cycles of garbage on all lanes, so a design that recorded errors during the settle interval would fill every row of the map. A restart pulse in mid-sweep and two different dwell requests expose a design that restarts while busy, ignores the 1024 floor, or miscounts the window.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    localparam int DCS_LANES     = 4;
    localparam int DCS_LANE_W    = 14;
    localparam int DCS_TAPS      = 32;
    localparam int DCS_SETTLE    = 16;
    localparam int DCS_MIN_DWELL = 1024;
    localparam int DCS_MIN_RUN   = 3;
    localparam int DCS_DWELL_W   = 16;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOAD   = 3'd1,
        ST_SETTLE = 3'd2,
        ST_DWELL  = 3'd3,
        ST_PICK   = 3'd4,
        ST_FINISH = 3'd5
    } sweep_state_e;

    // Controls the sequencer hands to the datapath each cycle.
    typedef struct packed {
        logic busy;
        logic sweep_phase;
        logic chk_en;
        logic clr_err;
        logic map_wr;
        logic step_load;
        logic pick;
        logic done;
    } sweep_ctl_t;

endpackage

// File: rtl/dcs_ramp_check.sv
module dcs_ramp_check
    import dcs_pkg::*;
#(
    parameter int LANES  = DCS_LANES,
    parameter int LANE_W = DCS_LANE_W,
    localparam int NBITS = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NBITS-1:0] data_i,
    input  logic             chk_en,
    input  logic             clr,
    output logic [NBITS-1:0] err_now_o,
    output logic [NBITS-1:0] sticky_o
);

    logic [NBITS-1:0] prev_q;
    logic [NBITS-1:0] sticky_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
        end else begin
            prev_q <= data_i;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] expect_w;
        assign expect_w = prev_q[l*LANE_W +: LANE_W] + LANE_W'(1);
        assign err_now_o[l*LANE_W +: LANE_W] =
            chk_en ? (data_i[l*LANE_W +: LANE_W] ^ expect_w) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sticky_q <= '0;
        end else begin
            sticky_q <= sticky_q | err_now_o;
        end
    end

    assign sticky_o = sticky_q;

endmodule

// File: rtl/dcs_err_map.sv
module dcs_err_map
    import dcs_pkg::*;
#(
    parameter int NBITS = DCS_LANES * DCS_LANE_W,
    parameter int TAPS  = DCS_TAPS,
    localparam int TAP_W = $clog2(TAPS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [TAP_W-1:0]      wr_row,
    input  logic [NBITS-1:0]      wr_data,
    input  logic [TAP_W-1:0]      rd_row,
    output logic [NBITS-1:0]      rd_data,
    output logic [NBITS*TAPS-1:0] col_o
);

    logic [NBITS-1:0] rows_q [TAPS];

    for (genvar t = 0; t < TAPS; t++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst) begin
                rows_q[t] <= '0;
            end else if (wr_en && (wr_row == TAP_W'(t))) begin
                rows_q[t] <= wr_data;
            end
        end
        for (genvar b = 0; b < NBITS; b++) begin : g_col
            assign col_o[b*TAPS + t] = rows_q[t][b];
        end
    end

    assign rd_data = rows_q[rd_row];

endmodule

// File: rtl/dcs_win_pick.sv
module dcs_win_pick
    import dcs_pkg::*;
#(
    parameter int TAPS    = DCS_TAPS,
    parameter int MIN_RUN = DCS_MIN_RUN,
    localparam int TAP_W  = $clog2(TAPS),
    localparam int LEN_W  = $clog2(TAPS + 1)
) (
    input  logic [TAPS-1:0]  col_i,
    output logic [TAP_W-1:0] tap_o,
    output logic             good_o
);

    logic [LEN_W-1:0] best_len, cur_len;
    logic [TAP_W-1:0] best_start, cur_start;
    logic [LEN_W-1:0] half_w;

    always_comb begin
        best_len   = '0;
        best_start = '0;
        cur_len    = '0;
        cur_start  = '0;
        for (int t = 0; t < TAPS; t++) begin
            if (!col_i[t]) begin
                if (cur_len == '0) begin
                    cur_start = TAP_W'(t);
                end
                cur_len = cur_len + LEN_W'(1);
                if (cur_len > best_len) begin
                    best_len   = cur_len;
                    best_start = cur_start;
                end
            end else begin
                cur_len = '0;
            end
        end
    end

    assign half_w = (best_len - LEN_W'(1)) >> 1;
    assign good_o = (best_len >= LEN_W'(MIN_RUN));
    assign tap_o  = good_o ? (best_start + TAP_W'(half_w)) : '0;

endmodule

// File: rtl/dcs_ctrl.sv
module dcs_ctrl
    import dcs_pkg::*;
#(
    parameter int TAPS      = DCS_TAPS,
    parameter int SETTLE    = DCS_SETTLE,
    parameter int MIN_DWELL = DCS_MIN_DWELL,
    parameter int DW_W      = DCS_DWELL_W,
    localparam int TAP_W    = $clog2(TAPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DW_W-1:0]  dwell_cfg,
    output sweep_ctl_t       ctl_o,
    output logic [TAP_W-1:0] tap_cur_o
);

    localparam logic [DW_W-1:0]  SETTLE_LAST = DW_W'(SETTLE - 1);
    localparam logic [DW_W-1:0]  DWELL_FLOOR = DW_W'(MIN_DWELL);
    localparam logic [TAP_W-1:0] TAP_LAST    = TAP_W'(TAPS - 1);

    sweep_state_e     state_q;
    logic [DW_W-1:0]  cnt_q;
    logic [DW_W-1:0]  dwell_q;
    logic [TAP_W-1:0] tap_q;
    logic             win_end;

    assign win_end = (state_q == ST_DWELL) && (cnt_q == dwell_q - DW_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            dwell_q <= DWELL_FLOOR;
            tap_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        tap_q   <= '0;
                        dwell_q <= (dwell_cfg < DWELL_FLOOR) ? DWELL_FLOOR : dwell_cfg;
                        state_q <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    cnt_q   <= '0;
                    state_q <= ST_SETTLE;
                end
                ST_SETTLE: begin
                    if (cnt_q == SETTLE_LAST) begin
                        cnt_q   <= '0;
                        state_q <= ST_DWELL;
                    end else begin
                        cnt_q <= cnt_q + DW_W'(1);
                    end
                end
                ST_DWELL: begin
                    if (win_end) begin
                        cnt_q <= '0;
                        if (tap_q == TAP_LAST) begin
                            state_q <= ST_PICK;
                        end else begin
                            tap_q   <= tap_q + TAP_W'(1);
                            state_q <= ST_LOAD;
                        end
                    end else begin
                        cnt_q <= cnt_q + DW_W'(1);
                    end
                end
                ST_PICK:   state_q <= ST_FINISH;
                ST_FINISH: state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl_o.busy        = (state_q != ST_IDLE);
        ctl_o.sweep_phase = (state_q == ST_LOAD) || (state_q == ST_SETTLE) ||
                            (state_q == ST_DWELL) || (state_q == ST_PICK);
        ctl_o.chk_en      = (state_q == ST_DWELL);
        ctl_o.clr_err     = (state_q == ST_LOAD) || (state_q == ST_SETTLE);
        ctl_o.map_wr      = win_end;
        ctl_o.step_load   = (state_q == ST_LOAD);
        ctl_o.pick        = (state_q == ST_PICK);
        ctl_o.done        = (state_q == ST_FINISH);
    end

    assign tap_cur_o = tap_q;

endmodule

// File: rtl/dly_cal_sweeper.sv
module dly_cal_sweeper
    import dcs_pkg::*;
#(
    parameter int LANES     = DCS_LANES,
    parameter int LANE_W    = DCS_LANE_W,
    parameter int TAPS      = DCS_TAPS,
    parameter int SETTLE    = DCS_SETTLE,
    parameter int MIN_DWELL = DCS_MIN_DWELL,
    parameter int MIN_RUN   = DCS_MIN_RUN,
    parameter int DW_W      = DCS_DWELL_W,
    localparam int NBITS    = LANES * LANE_W,
    localparam int TAP_W    = $clog2(TAPS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [DW_W-1:0]        dwell_cfg,
    input  logic [NBITS-1:0]       lane_data,
    output logic [NBITS*TAP_W-1:0] tap_out,
    output logic [NBITS-1:0]       tap_load,
    output logic                   busy,
    output logic                   done,
    output logic [NBITS-1:0]       fail_mask,
    input  logic [TAP_W-1:0]       row_sel,
    output logic [NBITS-1:0]       row_bits
);

    sweep_ctl_t                    ctl;
    logic [TAP_W-1:0]              tap_cur;
    logic [NBITS-1:0]              err_now, err_sticky;
    logic [NBITS*TAPS-1:0]         map_cols;
    logic [NBITS-1:0][TAP_W-1:0]   pick_tap;
    logic [NBITS-1:0]              pick_good;
    logic [NBITS-1:0][TAP_W-1:0]   final_q;
    logic [NBITS-1:0]              fail_q;

    dcs_ctrl #(
        .TAPS(TAPS), .SETTLE(SETTLE), .MIN_DWELL(MIN_DWELL), .DW_W(DW_W)
    ) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .dwell_cfg(dwell_cfg),
        .ctl_o(ctl), .tap_cur_o(tap_cur)
    );

    dcs_ramp_check #(.LANES(LANES), .LANE_W(LANE_W)) u_check (
        .clk(clk), .rst(rst), .data_i(lane_data),
        .chk_en(ctl.chk_en), .clr(ctl.clr_err),
        .err_now_o(err_now), .sticky_o(err_sticky)
    );

    dcs_err_map #(.NBITS(NBITS), .TAPS(TAPS)) u_map (
        .clk(clk), .rst(rst),
        .wr_en(ctl.map_wr), .wr_row(tap_cur), .wr_data(err_sticky | err_now),
        .rd_row(row_sel), .rd_data(row_bits), .col_o(map_cols)
    );

    for (genvar b = 0; b < NBITS; b++) begin : g_bit
        dcs_win_pick #(.TAPS(TAPS), .MIN_RUN(MIN_RUN)) u_pick (
            .col_i(map_cols[b*TAPS +: TAPS]),
            .tap_o(pick_tap[b]),
            .good_o(pick_good[b])
        );
        assign tap_out[b*TAP_W +: TAP_W] = ctl.sweep_phase ? tap_cur : final_q[b];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            final_q <= '0;
            fail_q  <= '0;
        end else if (ctl.pick) begin
            final_q <= pick_tap;
            fail_q  <= ~pick_good;
        end
    end

    assign tap_load  = {NBITS{ctl.step_load | ctl.done}};
    assign busy      = ctl.busy;
    assign done      = ctl.done;
    assign fail_mask = fail_q;

endmodule

// File: rtl/dcs_checker.sv
module dcs_checker #(
    parameter int NBITS = 56,
    parameter int TAP_W = 5
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   busy,
    input logic                   done,
    input logic [NBITS-1:0]       tap_load,
    input logic [NBITS*TAP_W-1:0] tap_out,
    input logic [NBITS-1:0]       fail_mask
);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_final_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (&tap_load));

    assert_strobe_all_R4: assert property (@(posedge clk) disable iff (rst)
        (|tap_load) |-> (&tap_load));

    assert_sweep_begin_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ((&tap_load) && (tap_out == '0)));

    assert_uniform_tap_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && (|tap_load)) |-> (tap_out == {NBITS{tap_out[TAP_W-1:0]}}));

    assert_hold_busy_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    always @(posedge clk) begin
        if (!rst && done) begin
            for (int b = 0; b < NBITS; b++) begin
                if (fail_mask[b]) begin
                    assert_fail_tap_zero_R8: assert (tap_out[b*TAP_W +: TAP_W] == '0);
                end
            end
        end
    end

endmodule

bind dly_cal_sweeper dcs_checker #(.NBITS(NBITS), .TAP_W(TAP_W)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done),
    .tap_load(tap_load), .tap_out(tap_out), .fail_mask(fail_mask)
);

// File: tb/dly_cal_sweeper_tb.sv
module dly_cal_sweeper_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LANES  = 4;
    localparam int LANE_W = 14;
    localparam int NBITS  = LANES * LANE_W;
    localparam int TAPS   = 32;
    localparam int TAP_W  = 5;

    // {bad-tap mask[31:0], expected tap[4:0], expected fail}
    localparam logic [37:0] PAT [0:7] = '{
        {32'h0000_0000, 5'd15, 1'b0},   // all clean
        {32'hFFFF_FFFF, 5'd0,  1'b1},   // dead at every tap
        {32'hFFE0_03FF, 5'd15, 1'b0},   // clean 10..20
        {32'hFF0F_FFC3, 5'd3,  1'b0},   // tie 2..5 vs 20..23
        {32'hFFFF_FE7F, 5'd0,  1'b1},   // only two clean taps
        {32'h8FFF_FFFF, 5'd29, 1'b0},   // exactly three 28..30
        {32'h01FF_FFF0, 5'd28, 1'b0},   // ends: 0..3 vs 25..31
        {32'h0008_0060, 5'd12, 1'b0}    // tie 7..18 vs 20..31
    };

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   start = 1'b0;
    logic [15:0]            dwell_cfg = '0;
    logic [NBITS-1:0]       lane_data = '0;
    logic [NBITS*TAP_W-1:0] tap_out;
    logic [NBITS-1:0]       tap_load;
    logic                   busy, done;
    logic [NBITS-1:0]       fail_mask;
    logic [TAP_W-1:0]       row_sel = '0;
    logic [NBITS-1:0]       row_bits;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dly_cal_sweeper u_dut (
        .clk(clk), .rst(rst), .start(start), .dwell_cfg(dwell_cfg),
        .lane_data(lane_data), .tap_out(tap_out), .tap_load(tap_load),
        .busy(busy), .done(done), .fail_mask(fail_mask),
        .row_sel(row_sel), .row_bits(row_bits)
    );

    function automatic int pat_of(int b);
        return ((b % LANE_W) == 0) ? 0 : (b % 8);
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Stimulus: per-lane ramp, faults on even values only (no carry crosses
    // the faulty bit), garbage on all lanes for 8 cycles after each strobe.
    logic [LANE_W-1:0] ramp [LANES];
    int glitch = 0;

    initial begin
        ramp[0] = 14'd0;
        ramp[1] = 14'd777;
        ramp[2] = 14'd9000;
        ramp[3] = 14'd16300;
    end

    always @(negedge clk) begin : drive
        logic [NBITS-1:0]  d;
        logic [LANE_W-1:0] v, w;
        logic [TAP_W-1:0]  tp;
        if (tap_load != '0) glitch = 8;
        for (int l = 0; l < LANES; l++) begin
            v = ramp[l];
            w = v;
            for (int i = 1; i < LANE_W; i++) begin
                tp = tap_out[(l*LANE_W + i)*TAP_W +: TAP_W];
                if (!v[0] && PAT[pat_of(l*LANE_W + i)][6 + int'(tp)])
                    w[i] = ~w[i];
            end
            if (glitch > 0) w = w ^ 14'h2AAA;
            d[l*LANE_W +: LANE_W] = w;
            ramp[l] = v + 14'd1;
        end
        if (glitch > 0) glitch = glitch - 1;
        lane_data = d;
    end

    task automatic run_sweep(input logic [15:0] dw, input int exp_busy, input bit restart);
        int busy_cnt = 0;
        int done_cnt = 0;
        int exp_tap  = 0;
        int guard    = 0;
        dwell_cfg = dw;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (1) begin
            if (busy) busy_cnt++;
            if (tap_load != '0 && !done) begin
                check(tap_out == {NBITS{TAP_W'(exp_tap)}} && (&tap_load),
                      "R4 sweep tap", 64'(tap_out[TAP_W-1:0]), 64'(exp_tap));
                exp_tap++;
            end
            if (done) begin
                done_cnt++;
                check(&tap_load, "R9 final strobe", 64'(tap_load), {8'h0, {NBITS{1'b1}}});
            end
            start = (restart && busy_cnt == 100) ? 1'b1 : 1'b0;
            if (!busy) break;
            guard++;
            if (guard > 60000) begin
                check(1'b0, "watchdog sweep", 64'(guard), 64'(exp_busy));
                break;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(busy_cnt == exp_busy, "R5 R10 busy length", 64'(busy_cnt), 64'(exp_busy));
        check(done_cnt == 1, "R9 done pulses", 64'(done_cnt), 64'd1);
        check(exp_tap == TAPS, "R4 tap steps", 64'(exp_tap), 64'(TAPS));
    endtask

    task automatic check_results();
        logic [NBITS-1:0] exp_fail;
        logic [NBITS-1:0] exp_row;
        exp_fail = '0;
        for (int b = 0; b < NBITS; b++) begin
            logic [37:0] p;
            p = PAT[pat_of(b)];
            exp_fail[b] = p[0];
            check(tap_out[b*TAP_W +: TAP_W] == p[5:1],
                  p[0] ? "R8 failing bit tap" : "R7 window centre",
                  64'(tap_out[b*TAP_W +: TAP_W]), 64'(p[5:1]));
        end
        check(fail_mask == exp_fail, "R8 fail mask", 64'(fail_mask), 64'(exp_fail));
        for (int t = 0; t < TAPS; t++) begin
            row_sel = TAP_W'(t);
            #1;
            for (int b = 0; b < NBITS; b++) exp_row[b] = PAT[pat_of(b)][6 + t];
            check(row_bits == exp_row, "R6 R2 R3 map row", 64'(row_bits), 64'(exp_row));
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        check(1'b0, "watchdog global", 64'd0, 64'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R1 reset flags", {62'd0, busy, done}, 64'd0);
        check(tap_out == '0, "R1 reset taps", 64'(tap_out), 64'd0);
        check(tap_load == '0, "R1 reset strobe", 64'(tap_load), 64'd0);
        check(fail_mask == '0, "R1 reset mask", 64'(fail_mask), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0 && tap_load == '0 && fail_mask == '0, "R1 after reset",
              64'(busy), 64'd0);

        // dwell below floor -> 1024; restart pulse while busy (R10)
        run_sweep(16'd0, 32*(17+1024)+2, 1'b1);
        check_results();

        // longer window
        run_sweep(16'd1100, 32*(17+1100)+2, 1'b0);
        check_results();

        repeat (4) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R9 idle after done", {62'd0, busy, done}, 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule